// File: doc/BRIEF.md
# Mispredict Redirect Selector

This block sits at the end of the execute stage of an out-of-order core. Each cycle it receives a group of up to `SLOTS` executed instructions in program order. For every slot it gets a valid bit, a squashed bit, a mispredicted bit, the predicted branch direction, a sequence number, a PC and the computed target. It also receives one memory-order-violation indication, which names the slot it applies to and gives the sequence number of the instruction that caused it.

The block scans the group from slot 0 upward. At the first live, unsquashed slot that either mispredicted or carries the violation, it builds one redirect packet for fetch and rename. Any later events in the same group are dropped.

The block also forwards the group to commit. Every live slot is marked executed, including squashed slots and the mispredicting instruction itself. When the redirect comes from a violation, a notice carrying both sequence numbers also goes to the issue queue. All outputs are registered and describe the group presented one cycle earlier.

Top module: `redirect_select`

## Requirements
- R1: While `rst_n` is low, every output is 0.
- R2: A group ends at the first slot whose valid bit is 0. `cm_vld[i]` is 1 exactly when slots 0 through i are all valid. Slots past the end of the group cannot raise a redirect, even when they are valid.
- R3: A squashed live slot is forwarded with `cm_vld[i]=1` and `cm_squashed[i]=1`, and it never causes a redirect.
- R4: Only the lowest-numbered live, unsquashed slot that has an event produces a redirect. Events in slots above it have no effect on the packet.
- R5: A slot can be both mispredicted and the slot named by the violation. In that case it is treated as a mispredict: `rd_mispredict=1` and `iq_viol_vld=0`.
- R6: On a redirect, `rd_seq`, `rd_pc` and `rd_next_pc` equal the chosen slot's sequence number, PC and target.
- R7: For a mispredict, `rd_taken` is the inverse of the slot's predicted direction. For a violation, `rd_taken` is 0.
- R8: A mispredicted live slot is still forwarded as a valid, unsquashed executed instruction.
- R9: A violation counts only when `ord_viol` is 1 and `ord_viol_slot` indexes a live, unsquashed slot. The resulting redirect has `rd_squash=1` and `rd_mispredict=0`. It also raises `iq_viol_vld`, with `iq_viol_cur_seq` set to the chosen slot's sequence number and `iq_viol_src_seq` set to `ord_viol_seq`.
- R10: Outputs appear one cycle after the group is presented and last one cycle. When no slot redirects, `rd_squash`, `rd_mispredict`, `rd_taken` and `iq_viol_vld` are 0, and all redirect data fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| grp_vld | input | SLOTS | Per-slot valid |
| grp_squashed | input | SLOTS | Per-slot squashed mark |
| grp_mispred | input | SLOTS | Per-slot branch mispredicted |
| grp_pred_taken | input | SLOTS | Per-slot predicted direction |
| grp_seq | input | SLOTS*SEQ_W | Sequence numbers, slot i at bits [i*SEQ_W +: SEQ_W] |
| grp_pc | input | SLOTS*PC_W | PCs, slot i at bits [i*PC_W +: PC_W] |
| grp_target | input | SLOTS*PC_W | Computed next PCs, same packing as grp_pc |
| ord_viol | input | 1 | Memory-order violation present |
| ord_viol_slot | input | IDX_W | Slot the violation applies to |
| ord_viol_seq | input | SEQ_W | Sequence number of the violating instruction |
| cm_vld | output | SLOTS | Forwarded-to-commit valid (executed) |
| cm_squashed | output | SLOTS | Forwarded squashed mark |
| rd_squash | output | 1 | Redirect present |
| rd_mispredict | output | 1 | Redirect is a branch mispredict |
| rd_seq | output | SEQ_W | Sequence number of the redirecting instruction |
| rd_pc | output | PC_W | PC of the redirecting instruction |
| rd_next_pc | output | PC_W | Fetch restart PC |
| rd_taken | output | 1 | Actual branch direction |
| iq_viol_vld | output | 1 | Violation notice to the issue queue |
| iq_viol_cur_seq | output | SEQ_W | Sequence number of the instruction that redirected |
| iq_viol_src_seq | output | SEQ_W | Sequence number of the violating instruction |

## Verification
The hardest cases to reach are groups that carry several competing events. Examples are a violation in a lower slot than a mispredict, a mispredict and a violation on the same slot, an event hidden behind a squashed slot, and an event beyond a hole in the valid bits. Purely random groups seldom line these up. The stimulus therefore mixes random groups with a high event density and a set of directed groups that place each conflict on purpose. Every group is compared against a bench model of the in-order scan.

// File: rtl/redsel_pkg.sv
package redsel_pkg;

    typedef enum logic [1:0] {
        EV_NONE    = 2'd0,
        EV_MISPRED = 2'd1,
        EV_ORDER   = 2'd2
    } redir_kind_e;

endpackage

// File: rtl/redsel_slot_qual.sv
module redsel_slot_qual #(
    parameter int SLOTS = 4,
    parameter int IDX_W = 2
) (
    input  logic [SLOTS-1:0] vld,
    input  logic [SLOTS-1:0] squashed,
    input  logic [SLOTS-1:0] mispred,
    input  logic             viol,
    input  logic [IDX_W-1:0] viol_slot,
    output logic [SLOTS-1:0] live,
    output logic [SLOTS-1:0] ev_mis,
    output logic [SLOTS-1:0] ev_ord
);
    // live[i]: slots 0..i all valid (group ends at first hole)
    assign live[0] = vld[0];
    for (genvar i = 1; i < SLOTS; i++) begin : g_live
        assign live[i] = live[i-1] & vld[i];
    end

    for (genvar i = 0; i < SLOTS; i++) begin : g_ev
        logic eligible;
        assign eligible  = live[i] & ~squashed[i];
        assign ev_mis[i] = eligible & mispred[i];
        assign ev_ord[i] = eligible & viol & (viol_slot == IDX_W'(i));
    end
endmodule

// File: rtl/redsel_first_pick.sv
module redsel_first_pick #(
    parameter int SLOTS = 4,
    parameter int IDX_W = 2
) (
    input  logic [SLOTS-1:0] req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/redirect_select.sv
module redirect_select
    import redsel_pkg::*;
#(
    parameter int SLOTS = 4,
    parameter int SEQ_W = 16,
    parameter int PC_W  = 32,
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [SLOTS-1:0]       grp_vld,
    input  logic [SLOTS-1:0]       grp_squashed,
    input  logic [SLOTS-1:0]       grp_mispred,
    input  logic [SLOTS-1:0]       grp_pred_taken,
    input  logic [SLOTS*SEQ_W-1:0] grp_seq,
    input  logic [SLOTS*PC_W-1:0]  grp_pc,
    input  logic [SLOTS*PC_W-1:0]  grp_target,
    input  logic                   ord_viol,
    input  logic [IDX_W-1:0]       ord_viol_slot,
    input  logic [SEQ_W-1:0]       ord_viol_seq,
    output logic [SLOTS-1:0]       cm_vld,
    output logic [SLOTS-1:0]       cm_squashed,
    output logic                   rd_squash,
    output logic                   rd_mispredict,
    output logic [SEQ_W-1:0]       rd_seq,
    output logic [PC_W-1:0]        rd_pc,
    output logic [PC_W-1:0]        rd_next_pc,
    output logic                   rd_taken,
    output logic                   iq_viol_vld,
    output logic [SEQ_W-1:0]       iq_viol_cur_seq,
    output logic [SEQ_W-1:0]       iq_viol_src_seq
);
    typedef struct packed {
        logic [SLOTS-1:0] cm_vld;
        logic [SLOTS-1:0] cm_sq;
        logic             squash;
        logic             mispred;
        logic [SEQ_W-1:0] seq;
        logic [PC_W-1:0]  pc;
        logic [PC_W-1:0]  npc;
        logic             taken;
        logic             viol;
        logic [SEQ_W-1:0] viol_src;
    } out_t;

    out_t state_d, state_q;

    logic [SLOTS-1:0] live, ev_mis, ev_ord, ev_any;
    logic             hit;
    logic [IDX_W-1:0] hit_idx;
    redir_kind_e      kind;

    redsel_slot_qual #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_qual (
        .vld       (grp_vld),
        .squashed  (grp_squashed),
        .mispred   (grp_mispred),
        .viol      (ord_viol),
        .viol_slot (ord_viol_slot),
        .live      (live),
        .ev_mis    (ev_mis),
        .ev_ord    (ev_ord)
    );

    assign ev_any = ev_mis | ev_ord;

    redsel_first_pick #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_pick (
        .req   (ev_any),
        .found (hit),
        .idx   (hit_idx)
    );

    always_comb begin
        state_d        = '0;
        state_d.cm_vld = live;
        state_d.cm_sq  = live & grp_squashed;
        kind           = EV_NONE;
        if (hit) begin
            // mispredict wins over an ordering event on the same slot
            kind = ev_mis[hit_idx] ? EV_MISPRED : EV_ORDER;
        end
        if (kind != EV_NONE) begin
            state_d.squash = 1'b1;
            state_d.seq    = grp_seq[hit_idx*SEQ_W +: SEQ_W];
            state_d.pc     = grp_pc[hit_idx*PC_W +: PC_W];
            state_d.npc    = grp_target[hit_idx*PC_W +: PC_W];
        end
        if (kind == EV_MISPRED) begin
            state_d.mispred = 1'b1;
            state_d.taken   = ~grp_pred_taken[hit_idx];
        end
        if (kind == EV_ORDER) begin
            state_d.viol     = 1'b1;
            state_d.viol_src = ord_viol_seq;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign cm_vld          = state_q.cm_vld;
    assign cm_squashed     = state_q.cm_sq;
    assign rd_squash       = state_q.squash;
    assign rd_mispredict   = state_q.mispred;
    assign rd_seq          = state_q.seq;
    assign rd_pc           = state_q.pc;
    assign rd_next_pc      = state_q.npc;
    assign rd_taken        = state_q.taken;
    assign iq_viol_vld     = state_q.viol;
    assign iq_viol_cur_seq = state_q.viol ? state_q.seq : '0;
    assign iq_viol_src_seq = state_q.viol_src;
endmodule

// File: rtl/redirect_select_chk.sv
module redirect_select_chk #(
    parameter int SLOTS = 4,
    parameter int SEQ_W = 16,
    parameter int PC_W  = 32,
    parameter int IDX_W = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [SLOTS-1:0]       grp_vld,
    input logic [SLOTS-1:0]       grp_squashed,
    input logic [SLOTS-1:0]       grp_mispred,
    input logic [SLOTS*SEQ_W-1:0] grp_seq,
    input logic [SLOTS-1:0]       cm_vld,
    input logic [SLOTS-1:0]       cm_squashed,
    input logic                   rd_squash,
    input logic                   rd_mispredict,
    input logic [SEQ_W-1:0]       rd_seq,
    input logic [PC_W-1:0]        rd_pc,
    input logic [PC_W-1:0]        rd_next_pc,
    input logic                   rd_taken,
    input logic                   iq_viol_vld,
    input logic [SEQ_W-1:0]       iq_viol_cur_seq
);
    logic primed;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) primed <= 1'b0;
        else        primed <= 1'b1;
    end

    logic slot0_mis;
    assign slot0_mis = grp_vld[0] & ~grp_squashed[0] & grp_mispred[0];

    assert_slot0_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        primed && $past(slot0_mis) |-> rd_squash && rd_mispredict
                                      && rd_seq == $past(grp_seq[SEQ_W-1:0]));

    assert_mispred_forwarded_R8: assert property (@(posedge clk) disable iff (!rst_n)
        primed && $past(grp_vld[0] && grp_mispred[0]) |-> cm_vld[0]);

    assert_all_squashed_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        primed && $past(&grp_squashed) |-> !rd_squash);

    assert_hole_at_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        primed && $past(!grp_vld[0]) |-> cm_vld == '0 && !rd_squash);

    assert_viol_kind_R9: assert property (@(posedge clk) disable iff (!rst_n)
        iq_viol_vld |-> rd_squash && !rd_mispredict && iq_viol_cur_seq == rd_seq);

    assert_idle_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_squash |-> !rd_mispredict && !iq_viol_vld && !rd_taken
                       && rd_seq == '0 && rd_pc == '0 && rd_next_pc == '0);

    assert_sq_subset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cm_squashed & ~cm_vld) == '0);
endmodule

bind redirect_select redirect_select_chk #(
    .SLOTS(SLOTS), .SEQ_W(SEQ_W), .PC_W(PC_W), .IDX_W(IDX_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .grp_vld         (grp_vld),
    .grp_squashed    (grp_squashed),
    .grp_mispred     (grp_mispred),
    .grp_seq         (grp_seq),
    .cm_vld          (cm_vld),
    .cm_squashed     (cm_squashed),
    .rd_squash       (rd_squash),
    .rd_mispredict   (rd_mispredict),
    .rd_seq          (rd_seq),
    .rd_pc           (rd_pc),
    .rd_next_pc      (rd_next_pc),
    .rd_taken        (rd_taken),
    .iq_viol_vld     (iq_viol_vld),
    .iq_viol_cur_seq (iq_viol_cur_seq)
);

// File: tb/redirect_select_test.sv
`timescale 1ns/1ps
module redirect_select_test;
    localparam int SLOTS = 4;
    localparam int SEQ_W = 16;
    localparam int PC_W  = 32;
    localparam int IDX_W = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [SLOTS-1:0]       grp_vld = '0, grp_squashed = '0, grp_mispred = '0, grp_pred_taken = '0;
    logic [SLOTS*SEQ_W-1:0] grp_seq = '0;
    logic [SLOTS*PC_W-1:0]  grp_pc = '0, grp_target = '0;
    logic                   ord_viol = 1'b0;
    logic [IDX_W-1:0]       ord_viol_slot = '0;
    logic [SEQ_W-1:0]       ord_viol_seq = '0;

    logic [SLOTS-1:0] cm_vld, cm_squashed;
    logic             rd_squash, rd_mispredict, rd_taken, iq_viol_vld;
    logic [SEQ_W-1:0] rd_seq, iq_viol_cur_seq, iq_viol_src_seq;
    logic [PC_W-1:0]  rd_pc, rd_next_pc;

    redirect_select #(.SLOTS(SLOTS), .SEQ_W(SEQ_W), .PC_W(PC_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .grp_vld(grp_vld), .grp_squashed(grp_squashed), .grp_mispred(grp_mispred),
        .grp_pred_taken(grp_pred_taken), .grp_seq(grp_seq), .grp_pc(grp_pc),
        .grp_target(grp_target), .ord_viol(ord_viol), .ord_viol_slot(ord_viol_slot),
        .ord_viol_seq(ord_viol_seq),
        .cm_vld(cm_vld), .cm_squashed(cm_squashed), .rd_squash(rd_squash),
        .rd_mispredict(rd_mispredict), .rd_seq(rd_seq), .rd_pc(rd_pc),
        .rd_next_pc(rd_next_pc), .rd_taken(rd_taken), .iq_viol_vld(iq_viol_vld),
        .iq_viol_cur_seq(iq_viol_cur_seq), .iq_viol_src_seq(iq_viol_src_seq)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int hit_slot;

    logic [SLOTS-1:0] e_cm_vld, e_cm_sq;
    logic             e_sq, e_mis, e_tk, e_iq;
    logic [SEQ_W-1:0] e_seq, e_cur, e_src;
    logic [PC_W-1:0]  e_pc, e_npc;

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Bench model of the in-order scan
    task automatic model();
        logic live;
        logic found;
        live = 1'b1; found = 1'b0;
        e_sq = 0; e_mis = 0; e_tk = 0; e_iq = 0; e_seq = '0; e_cur = '0; e_src = '0;
        e_pc = '0; e_npc = '0; hit_slot = -1;
        for (int i = 0; i < SLOTS; i++) begin
            live = live & grp_vld[i];
            e_cm_vld[i] = live;
            e_cm_sq[i]  = live & grp_squashed[i];
            if (live && !grp_squashed[i] && !found) begin
                if (grp_mispred[i]) begin
                    found = 1; e_mis = 1; e_tk = ~grp_pred_taken[i];
                end else if (ord_viol && ord_viol_slot == IDX_W'(i)) begin
                    found = 1; e_iq = 1; e_src = ord_viol_seq;
                end
                if (found) begin
                    hit_slot = i; e_sq = 1;
                    e_seq = grp_seq[i*SEQ_W +: SEQ_W];
                    e_pc  = grp_pc[i*PC_W +: PC_W];
                    e_npc = grp_target[i*PC_W +: PC_W];
                    if (e_iq) e_cur = e_seq;
                end
            end
        end
    endtask

    task automatic check_all(input string tag);
        chk({tag, "/R2"}, "cm_vld", 64'(cm_vld), 64'(e_cm_vld));
        chk({tag, "/R3"}, "cm_squashed", 64'(cm_squashed), 64'(e_cm_sq));
        chk({tag, "/R4"}, "rd_squash", 64'(rd_squash), 64'(e_sq));
        chk({tag, "/R5"}, "rd_mispredict", 64'(rd_mispredict), 64'(e_mis));
        chk({tag, "/R6"}, "rd_seq", 64'(rd_seq), 64'(e_seq));
        chk({tag, "/R6"}, "rd_pc", 64'(rd_pc), 64'(e_pc));
        chk({tag, "/R6"}, "rd_next_pc", 64'(rd_next_pc), 64'(e_npc));
        chk({tag, "/R7"}, "rd_taken", 64'(rd_taken), 64'(e_tk));
        chk({tag, "/R9"}, "iq_viol_vld", 64'(iq_viol_vld), 64'(e_iq));
        chk({tag, "/R9"}, "iq_viol_cur_seq", 64'(iq_viol_cur_seq), 64'(e_cur));
        chk({tag, "/R9"}, "iq_viol_src_seq", 64'(iq_viol_src_seq), 64'(e_src));
    endtask

    task automatic fill_data();
        for (int i = 0; i < SLOTS; i++) begin
            grp_seq[i*SEQ_W +: SEQ_W]  = SEQ_W'($urandom);
            grp_pc[i*PC_W +: PC_W]     = $urandom;
            grp_target[i*PC_W +: PC_W] = $urandom;
        end
        grp_pred_taken = SLOTS'($urandom);
        ord_viol_seq   = SEQ_W'($urandom);
    endtask

    // Drive at negedge, result visible after the next posedge: check at the following negedge.
    task automatic apply(input string tag, input logic [SLOTS-1:0] v, input logic [SLOTS-1:0] s,
                         input logic [SLOTS-1:0] m, input logic ov, input logic [IDX_W-1:0] os);
        @(negedge clk);
        fill_data();
        grp_vld = v; grp_squashed = s; grp_mispred = m; ord_viol = ov; ord_viol_slot = os;
        model();
        @(negedge clk);
        check_all(tag);
    endtask

    initial begin : watchdog
        #900000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "rd_squash", 64'(rd_squash), 0);
        chk("R1", "cm_vld", 64'(cm_vld), 0);
        chk("R1", "iq_viol_vld", 64'(iq_viol_vld), 0);
        chk("R1", "rd_pc", 64'(rd_pc), 0);
        rst_n = 1'b1;

        // Directed corner cases
        apply("R10_empty",      4'b0000, 4'b0000, 4'b0000, 1'b0, 2'd0);
        apply("R5_same_slot",   4'b1111, 4'b0000, 4'b0010, 1'b1, 2'd1);
        apply("R4_viol_first",  4'b1111, 4'b0000, 4'b1000, 1'b1, 2'd1);
        apply("R4_mis_first",   4'b1111, 4'b0000, 4'b0101, 1'b1, 2'd3);
        apply("R3_squashed",    4'b1111, 4'b0011, 4'b0011, 1'b1, 2'd0);
        apply("R2_hole",        4'b1101, 4'b0000, 4'b1000, 1'b1, 2'd3);
        apply("R8_forward",     4'b0001, 4'b0000, 4'b0001, 1'b0, 2'd0);
        apply("R9_viol_only",   4'b0111, 4'b0000, 4'b0000, 1'b1, 2'd2);
        // R10: one-cycle packet; quiet group right after a redirect
        apply("R10_after",      4'b1111, 4'b0000, 4'b0000, 1'b0, 2'd0);
        apply("R9_past_end",    4'b0011, 4'b0000, 4'b0000, 1'b1, 2'd3);

        // Random groups with a high event density
        for (int n = 0; n < 3000; n++) begin
            logic [SLOTS-1:0] v, s, m;
            v = ($urandom % 4 == 0) ? SLOTS'($urandom) : {SLOTS{1'b1}};
            s = SLOTS'($urandom & $urandom);
            m = SLOTS'($urandom & $urandom);
            apply("rand", v, s, m, 1'($urandom), IDX_W'($urandom));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule